// File: doc/BRIEF.md
# Byte-Wide Register Load Port

This block gives a host a narrow path into a bank of wide configuration registers. The host drives an 8-bit bus, two steering lines and a load strobe. Each strobe pulse is low-going. On the falling edge the block latches the steering lines. On the rising edge it stores the bus value into the address pointer, the lower eight bits of a register, or the upper four bits of a register. All nineteen 12-bit registers are visible at the same time on one flat output, for the timing logic that reads them.

The strobe arrives asynchronously. It passes through a two-flop synchroniser, and its edges are detected in the system clock domain. Loading an address with the byte-select line high starts sequential mode. In that mode, data strobes fill the current register low byte first and then high nibble, and the pointer advances after each high nibble. An asynchronous active-high clear puts every register back to its built-in default and restarts the load logic. Register 0 defaults to 0x400 or 0x000, selected by a parameter. Every other register defaults to zero.

Top module: `regLoadPort`

## Requirements
- R1: While clear is high, and after it falls, register 0 reads 0x400 when CLK_ON_DEFAULT=1 and 0x000 when it is 0, and registers 1..18 read 0x000; the pointer is 0 and sequential mode is off.
- R2: A strobe whose addrNotData was 0 at its falling edge loads dataBus into the pointer, and no register changes.
- R3: A data strobe (addrNotData=1) with hiSel=0 outside sequential mode writes dataBus into bits 7:0 of the pointed register and leaves bits 11:8 unchanged.
- R4: A data strobe with hiSel=1 outside sequential mode writes dataBus[3:0] into bits 11:8 and leaves bits 7:0 unchanged; dataBus[7:4] has no effect.
- R5: The addrNotData and hiSel values used are the ones present at the strobe's falling edge; changes while the strobe is low have no effect.
- R6: No register changes until the strobe's rising edge has been seen.
- R7: An address strobe with hiSel=1 enters sequential mode. Data strobes then write low byte, then high nibble, whatever hiSel is, and the pointer increments after each high nibble. An address strobe with hiSel=0 leaves sequential mode.
- R8: In sequential mode the pointer wraps from 18 to 0.
- R9: Data strobes with the pointer above 18 change no register.
- R10: Clear asserted mid-sequence restores all defaults and ends sequential mode, so the next low-byte strobe writes register 0 in plain mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clear | input | 1 | Asynchronous active-high clear to defaults |
| loadStrobe | input | 1 | Asynchronous load strobe, idle high |
| addrNotData | input | 1 | 0 = bus holds address, 1 = bus holds data |
| hiSel | input | 1 | 0 = low byte, 1 = high nibble / sequential-mode request |
| dataBus | input | 8 | Host data bus |
| regsFlat | output | 228 | Register i at bits [12*i+11 : 12*i] |

## Verification
The hardest behaviour to reach from the ports is a strobe whose steering lines change while it is low. This is the only way to show that the falling edge, and not the rising edge, fixes the strobe's meaning. The bench's strobe task takes separate steering values for the falling edge and for the rising edge. It switches between them after the falling edge has passed the synchroniser. The other hard case is the pointer wrap in sequential mode. The bench reaches it by starting sequential mode at address 17 and writing past the top of the bank. A behavioural model is compared against every register on each clock.

// File: rtl/regLoadPkg.sv
package regLoadPkg;

  // Strobes from control to datapath, one clock wide each
  typedef struct packed {
    logic ldAddr;
    logic wrLo;
    logic wrHi;
    logic incAddr;
  } loadStrobes_t;

endpackage

// File: rtl/regLoadCtrl.sv
module regLoadCtrl
  import regLoadPkg::*;
(
  input  logic         clk,
  input  logic         clear,
  input  logic         loadStrobe,
  input  logic         addrNotData,
  input  logic         hiSel,
  output loadStrobes_t strobes
);

  logic [1:0] loadSync;
  logic       loadPrev;
  logic       fallSeen, riseSeen;
  logic       capSel, capHi, armed;
  logic       autoMode, phaseHi;
  logic       act;

  // Two-flop synchroniser plus edge history, all idle high
  always_ff @(posedge clk or posedge clear) begin
    if (clear) begin
      loadSync <= 2'b11;
      loadPrev <= 1'b1;
    end else begin
      loadSync <= {loadSync[0], loadStrobe};
      loadPrev <= loadSync[1];
    end
  end

  assign fallSeen = loadPrev & ~loadSync[1];
  assign riseSeen = ~loadPrev & loadSync[1];
  assign act      = riseSeen & armed;

  always_ff @(posedge clk or posedge clear) begin
    if (clear) begin
      capSel   <= 1'b0;
      capHi    <= 1'b0;
      armed    <= 1'b0;
      autoMode <= 1'b0;
      phaseHi  <= 1'b0;
    end else begin
      if (fallSeen) begin
        capSel <= addrNotData;
        capHi  <= hiSel;
        armed  <= 1'b1;
      end else if (riseSeen) begin
        armed <= 1'b0;
      end
      if (act) begin
        if (!capSel) begin
          autoMode <= capHi;
          phaseHi  <= 1'b0;
        end else if (autoMode) begin
          phaseHi <= ~phaseHi;
        end
      end
    end
  end

  always_comb begin
    strobes         = '0;
    strobes.ldAddr  = act & ~capSel;
    strobes.wrLo    = act & capSel & (autoMode ? ~phaseHi : ~capHi);
    strobes.wrHi    = act & capSel & (autoMode ?  phaseHi :  capHi);
    strobes.incAddr = act & capSel & autoMode & phaseHi;
  end

  // R7: in sequential mode a low-byte write is followed by the high phase
  assert_auto_alternate_R7: assert property (@(posedge clk) disable iff (clear)
    (strobes.wrLo && autoMode) |=> phaseHi);

  // R6: nothing is issued unless the synchronised strobe just rose
  assert_rise_only_R6: assert property (@(posedge clk) disable iff (clear)
    (strobes.wrLo || strobes.wrHi || strobes.ldAddr) |-> (loadSync[1] && !loadPrev));

endmodule

// File: rtl/regLoadData.sv
module regLoadData
  import regLoadPkg::*;
#(
  parameter int  DATA_W         = 8,
  parameter int  REG_W          = 12,
  parameter int  NUM_REGS       = 19,
  parameter int  ENABLE_BIT     = 10,
  parameter bit  CLK_ON_DEFAULT = 1'b0
) (
  input  logic                      clk,
  input  logic                      clear,
  input  loadStrobes_t              strobes,
  input  logic [DATA_W-1:0]         dataBus,
  output logic [NUM_REGS*REG_W-1:0] regsFlat
);

  localparam int ADDR_W = DATA_W;
  localparam int HI_W   = REG_W - DATA_W;
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS - 1);

  logic [ADDR_W-1:0] addrQ;

  always_ff @(posedge clk or posedge clear) begin
    if (clear) begin
      addrQ <= '0;
    end else if (strobes.ldAddr) begin
      addrQ <= dataBus;
    end else if (strobes.incAddr) begin
      addrQ <= (addrQ >= LAST_ADDR) ? '0 : addrQ + 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [REG_W-1:0] DEF_VAL =
      (i == 0 && CLK_ON_DEFAULT) ? (REG_W'(1) << ENABLE_BIT) : '0;
    logic [REG_W-1:0] regQ;
    logic             hit;
    assign hit = (addrQ == ADDR_W'(i));

    always_ff @(posedge clk or posedge clear) begin
      if (clear) begin
        regQ <= DEF_VAL;
      end else begin
        if (strobes.wrLo && hit) regQ[DATA_W-1:0]     <= dataBus;
        if (strobes.wrHi && hit) regQ[REG_W-1:DATA_W] <= dataBus[HI_W-1:0];
      end
    end
    assign regsFlat[i*REG_W +: REG_W] = regQ;
  end

  // R3/R4: at most one action per strobe
  assert_one_action_R3: assert property (@(posedge clk) disable iff (clear)
    $onehot0({strobes.ldAddr, strobes.wrLo, strobes.wrHi}));

  // R2: address strobe captures the bus
  assert_addr_load_R2: assert property (@(posedge clk) disable iff (clear)
    strobes.ldAddr |=> addrQ == $past(dataBus));

  // R8: pointer wraps at the top of the bank
  assert_wrap_R8: assert property (@(posedge clk) disable iff (clear)
    (strobes.incAddr && addrQ == LAST_ADDR) |=> addrQ == '0);

  // R9: writes beyond the bank leave every register alone
  assert_ignore_high_R9: assert property (@(posedge clk) disable iff (clear)
    ((strobes.wrLo || strobes.wrHi) && addrQ > LAST_ADDR) |=> $stable(regsFlat));

  // R1: clear holds the defaults
  always @(posedge clk) begin
    if (clear) begin
      assert_defaults_R1: assert (regsFlat[REG_W-1:0] ==
        ((CLK_ON_DEFAULT) ? (REG_W'(1) << ENABLE_BIT) : '0));
    end
  end

endmodule

// File: rtl/regLoadPort.sv
module regLoadPort
  import regLoadPkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int REG_W          = 12,
  parameter int NUM_REGS       = 19,
  parameter bit CLK_ON_DEFAULT = 1'b0
) (
  input  logic                      clk,
  input  logic                      clear,
  input  logic                      loadStrobe,
  input  logic                      addrNotData,
  input  logic                      hiSel,
  input  logic [DATA_W-1:0]         dataBus,
  output logic [NUM_REGS*REG_W-1:0] regsFlat
);

  loadStrobes_t strobes;

  regLoadCtrl u_ctrl (
    .clk        (clk),
    .clear      (clear),
    .loadStrobe (loadStrobe),
    .addrNotData(addrNotData),
    .hiSel      (hiSel),
    .strobes    (strobes)
  );

  regLoadData #(
    .DATA_W        (DATA_W),
    .REG_W         (REG_W),
    .NUM_REGS      (NUM_REGS),
    .ENABLE_BIT    (10),
    .CLK_ON_DEFAULT(CLK_ON_DEFAULT)
  ) u_data (
    .clk     (clk),
    .clear   (clear),
    .strobes (strobes),
    .dataBus (dataBus),
    .regsFlat(regsFlat)
  );

endmodule

// File: tb/regLoadPort_tb.sv
module regLoadPort_tb;

  localparam int NR = 19;

  logic         clk = 1'b0;
  logic         clr;
  logic         loadStrobe;
  logic         addrNotData;
  logic         hiSel;
  logic [7:0]   dataBus;
  logic [NR*12-1:0] regsFlat;

  always #5 clk = ~clk;

  regLoadPort #(.CLK_ON_DEFAULT(1'b1)) u_dut (
    .clk        (clk),
    .clear      (clr),
    .loadStrobe (loadStrobe),
    .addrNotData(addrNotData),
    .hiSel      (hiSel),
    .dataBus    (dataBus),
    .regsFlat   (regsFlat)
  );

  // Behavioural reference
  int    model [NR];
  int    mAddr;
  bit    mAuto, mPhaseHi;
  int    vectors = 0, fails = 0;
  bit    running = 0, done = 0;
  string curReq = "R1";

  task automatic modelClear();
    for (int i = 0; i < NR; i++) model[i] = 0;
    model[0] = 'h400;
    mAddr = 0; mAuto = 0; mPhaseHi = 0;
  endtask

  task automatic modelWrite(input int a, input bit hi, input int d);
    if (a < NR) begin
      if (hi) model[a] = (model[a] & 'h0FF) | ((d & 'hF) << 8);
      else    model[a] = (model[a] & 'hF00) | (d & 'hFF);
    end
  endtask

  task automatic modelStrobe(input bit sel, input bit hi, input int d);
    if (!sel) begin
      mAddr = d; mAuto = hi; mPhaseHi = 0;
    end else if (mAuto) begin
      modelWrite(mAddr, mPhaseHi, d);
      if (mPhaseHi) mAddr = (mAddr >= NR - 1) ? 0 : mAddr + 1;
      mPhaseHi = !mPhaseHi;
    end else begin
      modelWrite(mAddr, hi, d);
    end
  endtask

  // Compare every register on every clock, away from the active edge
  always @(negedge clk) begin
    if (running && !done) begin
      bit bad = 0;
      vectors++;
      for (int i = 0; i < NR; i++) begin
        if (int'(regsFlat[i*12 +: 12]) != model[i]) begin
          $display("FAIL %s reg%0d actual=%03h expected=%03h", curReq, i,
                   regsFlat[i*12 +: 12], model[i]);
          bad = 1;
        end
      end
      if (bad) fails++;
    end
  end

  // Strobe: steering values at the falling edge, then at the rising edge
  task automatic strobe(input bit selF, input bit hiF, input bit selR,
                        input bit hiR, input logic [7:0] d, input string tag);
    curReq = tag;
    @(negedge clk);
    addrNotData = selF; hiSel = hiF; dataBus = d;
    loadStrobe = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    addrNotData = selR; hiSel = hiR;
    repeat (2) @(posedge clk);
    @(negedge clk);
    loadStrobe = 1'b1;
    repeat (3) @(posedge clk);
    modelStrobe(selF, hiF, d);
  endtask

  task automatic put(input bit sel, input bit hi, input logic [7:0] d,
                     input string tag);
    strobe(sel, hi, sel, hi, d, tag);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    $display("FAIL watchdog actual=running expected=finished");
    fails++;
    finishRun();
  end

  initial begin
    clr = 1'b0; loadStrobe = 1'b1; addrNotData = 1'b0; hiSel = 1'b0; dataBus = 8'h00;
    modelClear();
    #1 clr = 1'b1;
    #20 running = 1;
    curReq = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk); clr = 1'b0;
    repeat (3) @(posedge clk);

    // Plain address and byte/nibble writes
    put(0, 0, 8'd5,  "R2");
    put(1, 0, 8'hA5, "R3");
    put(1, 1, 8'hFC, "R4");
    put(1, 0, 8'h3C, "R3");
    put(0, 0, 8'd11, "R6");
    put(1, 1, 8'h07, "R6");

    // Steering changed while strobe is low
    strobe(1, 0, 1, 1, 8'h5E, "R5");
    strobe(0, 0, 1, 1, 8'd7,  "R5");
    strobe(1, 1, 0, 0, 8'h09, "R5");
    strobe(1, 1, 1, 0, 8'hE2, "R5");

    // Pointer outside the bank
    put(0, 0, 8'd19,  "R9");
    put(1, 0, 8'hFF,  "R9");
    put(1, 1, 8'hFF,  "R9");
    put(0, 0, 8'd200, "R9");
    put(1, 0, 8'h81,  "R9");
    put(0, 0, 8'd18,  "R9");
    put(1, 0, 8'h42,  "R9");

    // Sequential mode, hiSel toggled on purpose
    put(0, 1, 8'd2, "R7");
    for (int k = 0; k < 6; k++) put(1, k[0], 8'(k * 17 + 3), "R7");
    put(0, 0, 8'd3, "R7");
    put(1, 0, 8'h66, "R7");

    // Wrap
    put(0, 1, 8'd17, "R8");
    for (int k = 0; k < 6; k++) put(1, 1, 8'(8'hC0 + k), "R8");

    // Clear in the middle of sequential mode
    put(0, 1, 8'd4, "R10");
    put(1, 0, 8'h99, "R10");
    curReq = "R10";
    @(negedge clk); #2 clr = 1'b1; modelClear();
    repeat (2) @(posedge clk);
    @(negedge clk); #2 clr = 1'b0;
    repeat (2) @(posedge clk);
    put(1, 0, 8'h77, "R10");
    put(1, 0, 8'h78, "R10");

    repeat (4) @(posedge clk);
    @(negedge clk);
    finishRun();
  end

endmodule